// File: doc/BRIEF.md
# Low-Frequency Oscillator Enable Controller

This block decides when a low-frequency crystal oscillator runs, how hard its driver pushes, and whether the two oscillator pins belong to the oscillator or to general digital I/O. Three kinds of demand can start the oscillator. Peripherals such as a real-time clock, a timer or a watchdog can start it without any help from software. Software can start it early through a manual enable, so that the long start-up is already over when a peripheral first needs the clock. A 2-bit mode field chooses one of three settings: strong drive, weak low-power drive with a longer settling time, or no oscillator at all with the pins handed back to digital I/O.

A start-up counter stands in for the analog settling of the crystal. The clock-ready flag, and the gated clock output, appear only after that counter expires. A separate external-clock mode bypasses the crystal completely. In that mode the driver stays off, the manual enable is ignored, and a digital clock arriving on an input is passed straight through to the dependent peripherals.

Top module: `lfosc_ctrl`

## Requirements
- R1: While reset is held, `xtal_drv_en`, `low_drive_sel` and `clk_ready` are 0. With `mode_cfg`=11 and `ext_clk_mode`=0, `pin_dio_sel` is also 0.
- R2: Any bit of `periph_req` set, with `sw_enable`=0, `ext_clk_mode`=0 and `mode_cfg`≠00, sets `xtal_drv_en` on the next clock edge.
- R3: `sw_enable`=1 with no peripheral request, `ext_clk_mode`=0 and `mode_cfg`≠00, sets `xtal_drv_en` on the next clock edge.
- R4: In mode 11, `low_drive_sel` is 0 and `clk_ready` rises exactly HI_START clock edges after the edge that set `xtal_drv_en`.
- R5: In mode 01, `low_drive_sel` is 1 while the driver runs, and `clk_ready` rises exactly LO_START edges after the driver is enabled, where LO_START > HI_START.
- R6: Mode 10 behaves exactly like mode 11: strong drive and the HI_START settling time.
- R7: `pin_dio_sel` is 1 in mode 00 when not in external-clock mode. In that case the driver never starts, whatever the demand. `pin_dio_sel` is 0 in modes 01, 10 and 11.
- R8: With `ext_clk_mode`=1, the driver is off whatever `sw_enable` and `periph_req` are, `pin_dio_sel` is 0, `clk_ready` is 1, and `lf_clk_out` follows `ext_clk_in`.
- R9: When all demand goes away (no request, and either `sw_enable` is 0 or the block is in external-clock mode or mode 00), `xtal_drv_en` and the internal ready state clear on the next clock edge.
- R10: Re-enabling the driver after it was off, or switching between strong and weak drive while it runs, clears `clk_ready` at the next edge and restarts the full settling count for the new drive strength.
- R11: Outside external-clock mode, `lf_clk_out` equals `osc_clk_in` when `clk_ready` is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_cfg | input | 2 | 00 pins to digital I/O, 01 weak drive, 10 and 11 strong drive |
| sw_enable | input | 1 | Manual pre-start from software |
| periph_req | input | NREQ | One clock request line for each dependent peripheral |
| ext_clk_mode | input | 1 | 1 selects the external digital clock instead of the crystal |
| ext_clk_in | input | 1 | External digital clock |
| osc_clk_in | input | 1 | Raw output of the crystal oscillator |
| xtal_drv_en | output | 1 | Crystal driver enable |
| low_drive_sel | output | 1 | Weak-drive select for the crystal driver |
| pin_dio_sel | output | 1 | 1 gives the oscillator pins to digital I/O |
| clk_ready | output | 1 | Clock stable and usable |
| lf_clk_out | output | 1 | Clock sent to the dependent peripherals |

## Verification
The driver enable and the weak-drive select settle one edge after a demand change. The ready flag settles HI_START or LO_START edges after that edge. The pin select and the clock pass-through depend only on the current inputs and the ready state, with no clock edge in between. The bench changes inputs on falling edges and samples on later falling edges. It counts the rising edges in between, so a timing check lands one sample before and one sample after the edge where a result is due. The vector table instead waits longer than the longest settling time and checks only steady-state results.

// File: rtl/lfosc_pkg.sv
package lfosc_pkg;

   typedef enum logic [1:0] {
      LFM_PINS_DIO = 2'b00,
      LFM_LOW_DRV  = 2'b01,
      LFM_RSVD     = 2'b10,
      LFM_HIGH_DRV = 2'b11
   } lfm_e;

   typedef struct packed {
      logic osc_mode;
      logic low_drive;
      logic dio;
   } lf_dec_t;

endpackage

// File: rtl/lfosc_mode_dec.sv
module lfosc_mode_dec
   import lfosc_pkg::*;
#(
   parameter bit RSVD_AS_HIGH = 1'b1
) (
   input  logic [1:0] mode_cfg,
   input  logic       ext_clk_mode,
   output lf_dec_t    dec
);

   lfm_e mode;
   logic rsvd_osc;

   assign mode = lfm_e'(mode_cfg);

   generate
      if (RSVD_AS_HIGH) begin : g_rsvd_high
         assign rsvd_osc = 1'b1;
      end else begin : g_rsvd_dio
         assign rsvd_osc = 1'b0;
      end
   endgenerate

   always_comb begin
      dec = '0;
      if (!ext_clk_mode) begin
         unique case (mode)
            LFM_PINS_DIO: dec.dio = 1'b1;
            LFM_LOW_DRV: begin
               dec.osc_mode  = 1'b1;
               dec.low_drive = 1'b1;
            end
            LFM_RSVD: begin
               dec.osc_mode = rsvd_osc;
               dec.dio      = !rsvd_osc;
            end
            LFM_HIGH_DRV: dec.osc_mode = 1'b1;
            default: dec = '0;
         endcase
      end
   end

   always_comb begin
      if (ext_clk_mode) assert (dec == '0);
      assert (!(dec.dio && dec.osc_mode));
   end

endmodule

// File: rtl/lfosc_demand.sv
module lfosc_demand #(
   parameter int NREQ = 3
) (
   input  logic [NREQ-1:0] periph_req,
   input  logic            sw_enable,
   input  logic            ext_clk_mode,
   input  logic            osc_mode,
   output logic            want
);

   logic [NREQ:0] acc;

   assign acc[0] = sw_enable && !ext_clk_mode;

   generate
      for (genvar gi = 0; gi < NREQ; gi++) begin : g_or
         assign acc[gi+1] = acc[gi] | periph_req[gi];
      end
   endgenerate

   assign want = osc_mode && acc[NREQ];

endmodule

// File: rtl/lfosc_startup.sv
module lfosc_startup #(
   parameter int HI_START = 8,
   parameter int LO_START = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic want,
   input  logic want_low,
   output logic drv_en,
   output logic low_drv,
   output logic ready
);

   localparam int CW = $clog2(LO_START + 1);
   localparam logic [CW-1:0] HI_LAST = CW'(HI_START - 1);
   localparam logic [CW-1:0] LO_LAST = CW'(LO_START - 1);

   logic          drv_q, low_q, rdy_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] last;

   assign last = low_q ? LO_LAST : HI_LAST;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_q <= 1'b0;
         low_q <= 1'b0;
         rdy_q <= 1'b0;
         cnt_q <= '0;
      end else if (!want) begin
         drv_q <= 1'b0;
         low_q <= 1'b0;
         rdy_q <= 1'b0;
         cnt_q <= '0;
      end else if (!drv_q || (low_q != want_low)) begin
         drv_q <= 1'b1;
         low_q <= want_low;
         rdy_q <= 1'b0;
         cnt_q <= '0;
      end else if (!rdy_q) begin
         if (cnt_q == last) rdy_q <= 1'b1;
         else               cnt_q <= cnt_q + 1'b1;
      end
   end

   assign drv_en  = drv_q;
   assign low_drv = low_q;
   assign ready   = rdy_q;

   p_ready_needs_drv_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_q |-> drv_q);
   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LO_LAST);
   p_drop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !want |=> (!drv_q && !rdy_q));
   p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (want && !drv_q) |=> (drv_q && !rdy_q));
   p_strength_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (want && drv_q && (low_q != want_low)) |=> !rdy_q);

endmodule

// File: rtl/lfosc_ctrl.sv
module lfosc_ctrl
   import lfosc_pkg::*;
#(
   parameter int NREQ         = 3,
   parameter int HI_START     = 8,
   parameter int LO_START     = 20,
   parameter bit RSVD_AS_HIGH = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      mode_cfg,
   input  logic            sw_enable,
   input  logic [NREQ-1:0] periph_req,
   input  logic            ext_clk_mode,
   input  logic            ext_clk_in,
   input  logic            osc_clk_in,
   output logic            xtal_drv_en,
   output logic            low_drive_sel,
   output logic            pin_dio_sel,
   output logic            clk_ready,
   output logic            lf_clk_out
);

   generate
      if (NREQ < 1) begin : g_bad_nreq
         $error("NREQ must be at least 1");
      end
      if (HI_START < 2) begin : g_bad_hi
         $error("HI_START must be at least 2");
      end
      if (LO_START <= HI_START) begin : g_bad_lo
         $error("LO_START must exceed HI_START");
      end
   endgenerate

   lf_dec_t dec;
   logic    want;
   logic    rdy_int;

   lfosc_mode_dec #(.RSVD_AS_HIGH(RSVD_AS_HIGH)) u_dec (
      .mode_cfg     (mode_cfg),
      .ext_clk_mode (ext_clk_mode),
      .dec          (dec)
   );

   lfosc_demand #(.NREQ(NREQ)) u_dem (
      .periph_req   (periph_req),
      .sw_enable    (sw_enable),
      .ext_clk_mode (ext_clk_mode),
      .osc_mode     (dec.osc_mode),
      .want         (want)
   );

   lfosc_startup #(.HI_START(HI_START), .LO_START(LO_START)) u_su (
      .clk      (clk),
      .rst_n    (rst_n),
      .want     (want),
      .want_low (dec.low_drive),
      .drv_en   (xtal_drv_en),
      .low_drv  (low_drive_sel),
      .ready    (rdy_int)
   );

   assign pin_dio_sel = dec.dio;
   assign clk_ready   = ext_clk_mode | rdy_int;
   assign lf_clk_out  = ext_clk_mode ? ext_clk_in : (rdy_int & osc_clk_in);

   p_req_wakes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|periph_req && !ext_clk_mode && mode_cfg != 2'b00) |=> xtal_drv_en);
   p_sw_wakes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_enable && !ext_clk_mode && mode_cfg != 2'b00) |=> xtal_drv_en);
   p_low_only_when_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
      low_drive_sel |-> xtal_drv_en);
   p_dio_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pin_dio_sel |=> !xtal_drv_en);
   p_ext_blocks_drv_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ext_clk_mode |=> !xtal_drv_en);
   p_idle_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|periph_req) && !sw_enable) |=> !xtal_drv_en);

endmodule

// File: tb/lfosc_ctrl_bench.sv
`timescale 1ns/1ps
module lfosc_ctrl_bench;

   localparam int NREQ = 3;
   localparam int HI   = 8;
   localparam int LO   = 20;
   localparam int NV   = 8;
   // {ext, mode[1:0], sw, req[2:0], exp_drv, exp_low, exp_rdy, exp_dio}
   localparam logic [10:0] VEC [NV] = '{
      11'b0_11_0_001_1010,
      11'b0_01_0_010_1110,
      11'b0_10_1_000_1010,
      11'b0_00_1_111_0001,
      11'b1_11_1_100_0010,
      11'b0_11_0_000_0000,
      11'b0_00_0_000_0001,
      11'b1_00_0_000_0010
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] mode_cfg = 2'b11;
   logic sw_enable = 1'b0;
   logic [NREQ-1:0] periph_req = '0;
   logic ext_clk_mode = 1'b0;
   logic ext_clk_in = 1'b0;
   logic osc_clk_in = 1'b0;
   logic xtal_drv_en, low_drive_sel, pin_dio_sel, clk_ready, lf_clk_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   lfosc_ctrl #(.NREQ(NREQ), .HI_START(HI), .LO_START(LO)) u_lfosc_ctrl (
      .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .sw_enable(sw_enable),
      .periph_req(periph_req), .ext_clk_mode(ext_clk_mode),
      .ext_clk_in(ext_clk_in), .osc_clk_in(osc_clk_in),
      .xtal_drv_en(xtal_drv_en), .low_drive_sel(low_drive_sel),
      .pin_dio_sel(pin_dio_sel), .clk_ready(clk_ready), .lf_clk_out(lf_clk_out)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive(input logic e, input logic [1:0] m, input logic s,
                        input logic [NREQ-1:0] r);
      ext_clk_mode = e; mode_cfg = m; sw_enable = s; periph_req = r;
   endtask

   function automatic string vtag(input int i);
      case (i)
         0: return "R2 vector";
         1: return "R5 vector";
         2: return "R6 R3 vector";
         3: return "R7 vector";
         4: return "R8 vector";
         5: return "R9 vector";
         6: return "R7 idle vector";
         default: return "R8 idle vector";
      endcase
   endfunction

   initial begin
      #(200000 * 10);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      step(3);
      // R1 reset state
      chk("R1 drv", xtal_drv_en, 1'b0);
      chk("R1 low", low_drive_sel, 1'b0);
      chk("R1 rdy", clk_ready, 1'b0);
      chk("R1 dio", pin_dio_sel, 1'b0);
      rst_n = 1'b1;
      step(2);

      // steady-state table walk
      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][10], VEC[i][9:8], VEC[i][7], VEC[i][6:4]);
         step(LO + 4);
         chk(vtag(i), xtal_drv_en,   VEC[i][3]);
         chk(vtag(i), low_drive_sel, VEC[i][2]);
         chk(vtag(i), clk_ready,     VEC[i][1]);
         chk(vtag(i), pin_dio_sel,   VEC[i][0]);
      end

      // R4 strong-drive timing via request, R2 one-edge enable
      drive(1'b0, 2'b11, 1'b0, 3'b000); step(3);
      drive(1'b0, 2'b11, 1'b0, 3'b100);
      step(1);
      chk("R2 drv after 1 edge", xtal_drv_en, 1'b1);
      chk("R4 low", low_drive_sel, 1'b0);
      step(HI - 1);
      chk("R4 not ready at HI", clk_ready, 1'b0);
      step(1);
      chk("R4 ready at HI+1", clk_ready, 1'b1);

      // R11 clock gating when ready
      osc_clk_in = 1'b1; #1;
      chk("R11 pass high", lf_clk_out, 1'b1);
      osc_clk_in = 1'b0; #1;
      chk("R11 pass low", lf_clk_out, 1'b0);
      osc_clk_in = 1'b1;

      // R10 strength change restarts at LO
      step(1);
      drive(1'b0, 2'b01, 1'b0, 3'b100);
      step(1);
      chk("R10 ready cleared", clk_ready, 1'b0);
      chk("R10 low drive", low_drive_sel, 1'b1);
      chk("R11 gated off", lf_clk_out, 1'b0);
      step(LO - 1);
      chk("R5 not ready at LO", clk_ready, 1'b0);
      step(1);
      chk("R5 ready at LO+1", clk_ready, 1'b1);

      // R9 drop all demand
      drive(1'b0, 2'b01, 1'b0, 3'b000);
      step(1);
      chk("R9 drv off", xtal_drv_en, 1'b0);
      chk("R9 rdy off", clk_ready, 1'b0);

      // R3 software pre-start, R6 reserved mode timing, R10 re-enable
      drive(1'b0, 2'b10, 1'b1, 3'b000);
      step(1);
      chk("R3 drv", xtal_drv_en, 1'b1);
      chk("R6 low", low_drive_sel, 1'b0);
      step(HI - 1);
      chk("R6 not ready at HI", clk_ready, 1'b0);
      step(1);
      chk("R6 ready at HI+1", clk_ready, 1'b1);

      // R8 external clock: sw ignored, driver off, clock passes
      drive(1'b1, 2'b11, 1'b1, 3'b000);
      step(1);
      chk("R8 drv off", xtal_drv_en, 1'b0);
      chk("R8 ready", clk_ready, 1'b1);
      ext_clk_in = 1'b1; osc_clk_in = 1'b0; #1;
      chk("R8 clk high", lf_clk_out, 1'b1);
      ext_clk_in = 1'b0; osc_clk_in = 1'b1; #1;
      chk("R8 clk low", lf_clk_out, 1'b0);

      // R7 mode 00 with every demand: no driver
      drive(1'b0, 2'b00, 1'b1, 3'b111);
      step(2);
      chk("R7 drv off", xtal_drv_en, 1'b0);
      chk("R7 dio", pin_dio_sel, 1'b1);
      chk("R11 no clock", lf_clk_out, 1'b0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule